// File: doc/BRIEF.md
# Power-of-two Region Memory Protection Checker

This block holds a parameterised set of memory protection regions. Each region has an address word and an 8-bit configuration byte. The block checks one physical byte address and a privilege flag against all regions every cycle. It returns read, write and execute permission one clock later. A region is either OFF, a naturally aligned power-of-two range, or a single 4-byte word (NA4). Range-style (top-of-range) matching is not offered.

The register write port legalises every value it accepts. The minimum region size is set by a granularity parameter G and equals 1 << (G+2) bytes. When G > 1, the low G-1 address bits are forced: they read 0 while the region is OFF and 1 while it is a power-of-two range. Selected regions can be fixed at elaboration time. A fixed region has constant, read-only contents, and the granularity rules do not apply to it.

When several regions match, the lowest-numbered one decides. A system therefore typically places fixed regions at the top indices, where programmable low regions can override them. A registered read port returns the legal value of any region.

Top module: `pmp_napot_chk`

## Requirements
- R1: After synchronous reset, every programmable region reads back configuration 0x00 and address 0. Fixed regions read back their elaboration-time values.
- R2: Configuration byte layout: bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the mode, and bit 7 is lock. Mode values are 0 OFF, 1 top-of-range, 2 NA4 and 3 power-of-two. A write of mode 1 stores OFF, and bits 6:5 always read 0.
- R3: When G > 0, writing mode 2 (NA4) to a programmable region stores OFF instead.
- R4: When G > 1, the low G-1 bits of a programmable region's address read 0 while its mode is OFF and 1 while its mode is power-of-two. The matcher uses the value as read.
- R5: A power-of-two region with k trailing one bits in its address word covers 2^(k+3) bytes. The match compares byte-address bits from k+3 upward with address-word bits from k+1 upward.
- R6: When several regions match, the lowest-numbered region decides the result.
- R7: With no matching region, a machine-mode access gets all three permissions and a user-mode access gets none. The hit output is then 0.
- R8: For a matching region, a user-mode access gets the region's read, write and execute bits. A machine-mode access gets those bits only when the region's lock bit is set; otherwise it gets all three.
- R9: While a programmable region's lock bit is set, writes to its configuration or address are ignored until reset.
- R10: Fixed regions ignore all writes, take no granularity masking, and match with their fixed values.
- R11: Permission and hit outputs reflect the check inputs sampled at the previous clock edge. Read-port outputs reflect the region selected at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_is_cfg | input | 1 | 1 writes the configuration byte, 0 writes the address word |
| wr_idx | input | IW | Region written |
| wr_data | input | AW | Write value (configuration uses bits 7:0) |
| rd_idx | input | IW | Region read back |
| rd_cfg | output | 8 | Legal configuration of the selected region |
| rd_addr | output | AW | Legal address word of the selected region |
| chk_addr | input | PADDR_W | Byte address under check |
| chk_priv_m | input | 1 | 1 for machine mode, 0 for user mode |
| allow_r | output | 1 | Read permitted |
| allow_w | output | 1 | Write permitted |
| allow_x | output | 1 | Execute permitted |
| chk_hit | output | 1 | Some region matched |

## Verification
Accesses are aimed just inside and just past a 64-byte range, which separates a correct size decode from an off-by-one in the trailing-ones mask. A 16-byte programmable region is placed inside the fixed 256 MB region. Probing both it and the space outside it shows that priority goes by index and not by size. The same address is issued in machine and user mode, with the lock bit clear and then set, which separates the lock-gated machine rule from the plain user rule. Back-to-back checks with different addresses confirm the one-cycle result latency.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } pmp_mode_e;

  localparam int CFG_W    = 8;
  localparam int LOCK_BIT = 7;

  // Legalise a configuration write: clear reserved bits, drop unsupported modes.
  function automatic logic [7:0] legal_cfg(input logic [7:0] d, input int g);
    logic [1:0] m;
    m = d[4:3];
    if (m == MODE_TOR) m = MODE_OFF;
    if (m == MODE_NA4 && g > 0) m = MODE_OFF;
    return {d[7], 2'b00, m, d[2:0]};
  endfunction

endpackage

// File: rtl/pmp_region.sv
module pmp_region
  import pmp_pkg::*;
#(
  parameter int AW = 30,
  parameter int G = 2,
  parameter bit HARD = 1'b0,
  parameter logic [AW-1:0] HW_A = '0,
  parameter logic [7:0] HW_C = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cfg,
  input  logic          wr_addr,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] chk_word,
  output logic [7:0]    cfg_o,
  output logic [AW-1:0] addr_o,
  output logic          match_o
);

  localparam int LOWN = (G > 1) ? (G - 1) : 0;
  localparam logic [AW-1:0] LOWM = AW'((64'd1 << LOWN) - 64'd1);

  generate
    if (HARD) begin : g_fixed
      logic unused_wr;
      assign unused_wr = ^{clk, rst, wr_cfg, wr_addr, wr_data};
      assign cfg_o  = HW_C;
      assign addr_o = HW_A;
    end else begin : g_prog
      logic [7:0]    cfg_r;
      logic [AW-1:0] addr_r;
      logic          napot;

      always_ff @(posedge clk) begin
        if (rst) begin
          cfg_r  <= '0;
          addr_r <= '0;
        end else if (!cfg_r[LOCK_BIT]) begin
          if (wr_cfg)  cfg_r  <= legal_cfg(wr_data[7:0], G);
          if (wr_addr) addr_r <= wr_data;
        end
      end

      assign napot  = (cfg_r[4:3] == MODE_NAPOT);
      assign cfg_o  = cfg_r;
      assign addr_o = (addr_r & ~LOWM) | (napot ? LOWM : '0);

      // R9: a locked region holds its configuration and address
      a_r9_lock_cfg: assert property (@(posedge clk) disable iff (rst)
        (cfg_r[LOCK_BIT] && wr_cfg) |=> $stable(cfg_r));
      a_r9_lock_addr: assert property (@(posedge clk) disable iff (rst)
        (cfg_r[LOCK_BIT] && wr_addr) |=> $stable(addr_r));
      // R4: an unlocked address write is stored whole; masking applies only on read
      a_r4_addr_store: assert property (@(posedge clk) disable iff (rst)
        (!cfg_r[LOCK_BIT] && wr_addr) |=> (addr_r == $past(wr_data)));
      if (G > 0) begin : g_chk_na4
        // R3: NA4 can never be held when the grain exceeds one word
        a_r3_no_na4: assert property (@(posedge clk) disable iff (rst)
          cfg_r[4:3] != MODE_NA4);
      end
    end
  endgenerate

  // Match logic on the legal (read-back) address value
  logic [AW-1:0] care;
  logic          napot_hit;
  logic          na4_hit;

  assign care      = ~(addr_o ^ (addr_o + AW'(1)));
  assign napot_hit = (((chk_word ^ addr_o) & care) == '0);
  assign na4_hit   = (chk_word == addr_o);
  assign match_o   = ((cfg_o[4:3] == MODE_NAPOT) && napot_hit) ||
                     ((cfg_o[4:3] == MODE_NA4) && na4_hit);

endmodule

// File: rtl/pmp_prio.sv
module pmp_prio
  import pmp_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic [NREG*8-1:0] cfg_all,
  input  logic [NREG-1:0]   match_all,
  input  logic              priv_m,
  output logic              hit,
  output logic [2:0]        perm
);

  always_comb begin
    hit  = 1'b0;
    perm = priv_m ? 3'b111 : 3'b000;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match_all[i]) begin
        hit  = 1'b1;
        perm = (priv_m && !cfg_all[i*8+LOCK_BIT]) ? 3'b111 : cfg_all[i*8 +: 3];
      end
    end
  end

endmodule

// File: rtl/pmp_napot_chk.sv
module pmp_napot_chk
  import pmp_pkg::*;
#(
  parameter int NREG = 4,
  parameter int PADDR_W = 32,
  parameter int G = 2,
  parameter int AW = PADDR_W - 2,
  parameter int IW = (NREG > 1) ? $clog2(NREG) : 1,
  parameter logic [NREG-1:0] HW_MASK = 4'b1000,
  parameter logic [NREG*AW-1:0] HW_ADDR = {30'h11FF_FFFF, 90'd0},
  parameter logic [NREG*8-1:0] HW_CFG = {8'h19, 24'd0}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_is_cfg,
  input  logic [IW-1:0]      wr_idx,
  input  logic [AW-1:0]      wr_data,
  input  logic [IW-1:0]      rd_idx,
  output logic [7:0]         rd_cfg,
  output logic [AW-1:0]      rd_addr,
  input  logic [PADDR_W-1:0] chk_addr,
  input  logic               chk_priv_m,
  output logic               allow_r,
  output logic               allow_w,
  output logic               allow_x,
  output logic               chk_hit
);

  logic [NREG*8-1:0]  cfg_all;
  logic [NREG*AW-1:0] addr_all;
  logic [NREG-1:0]    match_all;
  logic [AW-1:0]      chk_word;
  logic [1:0]         unused_lsb;

  assign chk_word   = chk_addr[PADDR_W-1:2];
  assign unused_lsb = chk_addr[1:0];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic sel;
      assign sel = wr_en && (wr_idx == IW'(i));
      pmp_region #(
        .AW   (AW),
        .G    (G),
        .HARD (HW_MASK[i]),
        .HW_A (HW_ADDR[i*AW +: AW]),
        .HW_C (HW_CFG[i*8 +: 8])
      ) u_region (
        .clk      (clk),
        .rst      (rst),
        .wr_cfg   (sel && wr_is_cfg),
        .wr_addr  (sel && !wr_is_cfg),
        .wr_data  (wr_data),
        .chk_word (chk_word),
        .cfg_o    (cfg_all[i*8 +: 8]),
        .addr_o   (addr_all[i*AW +: AW]),
        .match_o  (match_all[i])
      );
    end
  endgenerate

  logic       hit_c;
  logic [2:0] perm_c;

  pmp_prio #(.NREG(NREG)) u_prio (
    .cfg_all   (cfg_all),
    .match_all (match_all),
    .priv_m    (chk_priv_m),
    .hit       (hit_c),
    .perm      (perm_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      allow_r <= 1'b0;
      allow_w <= 1'b0;
      allow_x <= 1'b0;
      chk_hit <= 1'b0;
      rd_cfg  <= '0;
      rd_addr <= '0;
    end else begin
      allow_r <= perm_c[0];
      allow_w <= perm_c[1];
      allow_x <= perm_c[2];
      chk_hit <= hit_c;
      if (int'(rd_idx) < NREG) begin
        rd_cfg  <= cfg_all[rd_idx*8 +: 8];
        rd_addr <= addr_all[rd_idx*AW +: AW];
      end else begin
        rd_cfg  <= '0;
        rd_addr <= '0;
      end
    end
  end

  // R7: with no matching region, a user access is fully denied on the next cycle
  a_r7_user_default: assert property (@(posedge clk) disable iff (rst)
    (!chk_priv_m && (match_all == '0)) |=> (!allow_r && !allow_w && !allow_x && !chk_hit));
  // R8: machine access hitting only unlocked regions at the winner gets full access
  a_r8_m_unlocked: assert property (@(posedge clk) disable iff (rst)
    (chk_priv_m && match_all[0] && !cfg_all[LOCK_BIT]) |=> (allow_r && allow_w && allow_x));

endmodule

// File: tb/sim_pmp_napot_chk.sv
module sim_pmp_napot_chk;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 30;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          wr_is_cfg = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [AW-1:0] wr_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [7:0]    rd_cfg;
  logic [AW-1:0] rd_addr;
  logic [31:0]   chk_addr = '0;
  logic          chk_priv_m = 1'b0;
  logic          allow_r, allow_w, allow_x, chk_hit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_napot_chk u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_is_cfg(wr_is_cfg), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_cfg(rd_cfg), .rd_addr(rd_addr),
    .chk_addr(chk_addr), .chk_priv_m(chk_priv_m), .allow_r(allow_r),
    .allow_w(allow_w), .allow_x(allow_x), .chk_hit(chk_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit is_cfg, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_is_cfg = is_cfg; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input int idx, input logic [7:0] ec, input logic [AW-1:0] ea);
    @(negedge clk);
    rd_idx = IW'(idx);
    @(negedge clk);
    check({req, " cfg"}, {24'd0, rd_cfg}, {24'd0, ec});
    check({req, " addr"}, {2'd0, rd_addr}, {2'd0, ea});
  endtask

  task automatic acc(input string req, input logic [31:0] a, input bit m,
                     input logic [3:0] exp_hrwx);
    @(negedge clk);
    chk_addr = a; chk_priv_m = m;
    @(negedge clk);
    check(req, {28'd0, chk_hit, allow_r, allow_w, allow_x}, {28'd0, exp_hrwx});
  endtask

  // R1 R10 R7 R8 reset state and fixed region
  task automatic t_reset;
    rd("R1 region0 reset", 0, 8'h00, 30'h0);
    rd("R10 fixed region3", 3, 8'h19, 30'h11FF_FFFF);
    acc("R7 user no match", 32'h0000_1000, 1'b0, 4'b0000);
    acc("R7 machine no match", 32'h0000_1000, 1'b1, 4'b0111);
    acc("R10 user in fixed region", 32'h4000_0010, 1'b0, 4'b1100);
    acc("R8 machine unlocked match", 32'h4000_0010, 1'b1, 4'b1111);
  endtask

  // R5 64-byte range boundaries
  task automatic t_napot64;
    wr(0, 1'b0, 30'h0800_0007);
    wr(0, 1'b1, 30'h1B);
    rd("R5 region0 readback", 0, 8'h1B, 30'h0800_0007);
    acc("R5 inside last word", 32'h2000_003C, 1'b0, 4'b1110);
    acc("R5 first byte", 32'h2000_0000, 1'b0, 4'b1110);
    acc("R5 one past end", 32'h2000_0040, 1'b0, 4'b0000);
  endtask

  // R4 forced low address bit follows mode
  task automatic t_grain;
    wr(1, 1'b0, 30'h0800_0101);
    rd("R4 off reads low zero", 1, 8'h00, 30'h0800_0100);
    wr(1, 1'b1, 30'h1C);
    wr(1, 1'b0, 30'h0800_0100);
    rd("R4 napot reads low one", 1, 8'h1C, 30'h0800_0101);
    acc("R4 16B region execute", 32'h2000_040C, 1'b0, 4'b1001);
    acc("R4 16B region end", 32'h2000_0410, 1'b0, 4'b0000);
  endtask

  // R2 R3 legalisation of configuration writes
  task automatic t_legal;
    wr(2, 1'b1, 30'h11);
    rd("R3 NA4 becomes OFF", 2, 8'h01, 30'h0);
    wr(2, 1'b1, 30'h09);
    rd("R2 TOR becomes OFF", 2, 8'h01, 30'h0);
    wr(2, 1'b1, 30'h7B);
    rd("R2 reserved bits cleared", 2, 8'h1B, 30'h1);
  endtask

  // R6 low region overrides fixed high region
  task automatic t_prio;
    wr(1, 1'b0, 30'h1000_0001);
    wr(1, 1'b1, 30'h18);
    acc("R6 low region wins", 32'h4000_0004, 1'b0, 4'b1000);
    acc("R6 fixed region outside override", 32'h4000_0010, 1'b0, 4'b1100);
  endtask

  // R8 R9 lock behaviour
  task automatic t_lock;
    wr(2, 1'b0, 30'h0C00_0001);
    wr(2, 1'b1, 30'h9C);
    acc("R8 machine locked read", 32'h3000_0000, 1'b1, 4'b1001);
    acc("R8 user locked", 32'h3000_0008, 1'b0, 4'b1001);
    wr(2, 1'b1, 30'h1F);
    wr(2, 1'b0, 30'h0);
    rd("R9 locked ignores writes", 2, 8'h9C, 30'h0C00_0001);
    acc("R9 match unchanged", 32'h3000_0000, 1'b1, 4'b1001);
  endtask

  // R10 fixed region ignores writes
  task automatic t_fixed;
    wr(3, 1'b1, 30'h00);
    wr(3, 1'b0, 30'h0);
    rd("R10 fixed after write", 3, 8'h19, 30'h11FF_FFFF);
    acc("R10 still matches", 32'h4800_0000, 1'b0, 4'b1100);
  endtask

  // R11 back-to-back checks
  task automatic t_pipe;
    @(negedge clk);
    chk_addr = 32'h2000_0000; chk_priv_m = 1'b0;
    @(negedge clk);
    check("R11 first result", {28'd0, chk_hit, allow_r, allow_w, allow_x}, 32'h0000_000E);
    chk_addr = 32'h0000_1000;
    @(negedge clk);
    check("R11 second result", {28'd0, chk_hit, allow_r, allow_w, allow_x}, 32'h0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_napot64();
    t_grain();
    t_legal();
    t_prio();
    t_lock();
    t_fixed();
    t_pipe();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule